// File: doc/BRIEF.md
# Address Buddy Request Pairing Unit

This unit sits in front of a memory interface on the high-priority request stream. A request that arrives while the unit is idle is not sent at once. It is held in a single holding slot, and a countdown starts for it. If another request arrives whose page address matches the held one, the two leave together as a pair. A page-address match means that address bits 36 down to 9 agree once the programmable mask is applied. Sending buddies together lets the memory controller serve both with one row opening.

The countdown start value depends on the request kind. Plane-data requests load one 6-bit wait value and address-translation requests load another. When the countdown runs out, the held request leaves alone, so the cost of waiting for a buddy has an upper bound. A bypass input turns the pairing off: incoming requests then go straight through, and anything still held is flushed.

The output has two lanes and is registered one clock after the deciding edge. Lane 0 carries a request released from the holding slot. Lane 1 carries the request that arrived on that edge. A pair flag marks the cycles in which the two lanes form a buddy pair.

Top module: `buddy_pair_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out0_valid`, `out1_valid` and `out_paired` are 0.
- R2: An incoming request matches the held request when their address bits 36..9 agree after masking; address bits 8..0 are never compared. On a match, in the next cycle lane 0 carries the held request, lane 1 carries the incoming one and `out_paired` is 1, and the holding slot becomes empty.
- R3: Bit i of `cfg_mask` (i = 0..27) stands for address bit i+9. A 1 removes that bit from the comparison, and a 0 keeps it.
- R4: A plane-data request (`in_kind` = 0) captured into an empty slot loads its countdown with `cfg_plane_wait` = T. If no buddy arrives, it is issued alone on lane 0 with `out_paired` = 0, visible after the (T+1)th rising edge following the capture edge. T = 0 gives one edge.
- R5: A translation request (`in_kind` = 1) loads its countdown from `cfg_xlat_wait` instead, with the same release timing as R4.
- R6: A request that does not match, arriving while the held countdown is still above zero, is issued alone on lane 1 in the next cycle. The held request keeps waiting and its countdown keeps running.
- R7: A request that does not match, arriving on the edge at which the held countdown is zero, causes the held request to be released alone on lane 0. The new request takes the holding slot with a freshly loaded countdown.
- R8: When a match and an expiry fall on the same edge, the pair is issued (R2) rather than a lone release.
- R9: While `cfg_bypass` is 1, an incoming request is issued on lane 1 in the next cycle and any held request is flushed on lane 0 in the same cycle. `out_paired` stays 0 and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bypass | input | 1 | 1 turns pairing off: pass-through and flush |
| cfg_mask | input | 28 | Per-bit exclusion mask for address bits 36..9 |
| cfg_plane_wait | input | 6 | Countdown start value for plane-data requests |
| cfg_xlat_wait | input | 6 | Countdown start value for translation requests |
| in_valid | input | 1 | Incoming request present |
| in_addr | input | 37 | Incoming physical address |
| in_kind | input | 1 | 0 = plane data, 1 = address translation |
| out0_valid | output | 1 | Lane 0 carries a request released from the slot |
| out0_addr | output | 37 | Lane 0 address |
| out0_kind | output | 1 | Lane 0 request kind |
| out1_valid | output | 1 | Lane 1 carries the request that just arrived |
| out1_addr | output | 37 | Lane 1 address |
| out1_kind | output | 1 | Lane 1 request kind |
| out_paired | output | 1 | Lanes 0 and 1 form a buddy pair |

## Verification
The assertions check several properties on every cycle:
- a pair always occupies both lanes, and its page addresses agree under the mask that was in force;
- lane 1 only ever repeats the request presented one cycle earlier;
- bypass never yields a pair, and it always passes an incoming request through;
- the outputs are idle when reset is released.

The countdown lengths for each request kind, the handover of the slot when a new request arrives at expiry, the precedence of pairing over expiry, and the flush on bypass depend on the history of events. Only the bench's reference model and its directed scenarios can show those.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
    typedef enum logic {
        KIND_PLANE = 1'b0,
        KIND_XLAT  = 1'b1
    } req_kind_e;
endpackage

// File: rtl/buddy_match.sv
module buddy_match #(
    parameter int ADDR_W  = 37,
    parameter int CMP_LSB = 9,
    localparam int MASK_W = ADDR_W - CMP_LSB
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    logic [MASK_W-1:0] diff;

    // One comparator bit per compared address bit; a set mask bit drops it.
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        assign diff[i] = (addr_a[i+CMP_LSB] ^ addr_b[i+CMP_LSB]) & ~mask[i];
    end

    assign hit = ~|diff;
endmodule

// File: rtl/buddy_wait_sel.sv
module buddy_wait_sel
    import buddy_pkg::*;
#(
    parameter int TMR_W = 6
) (
    input  logic             kind,
    input  logic [TMR_W-1:0] plane_wait,
    input  logic [TMR_W-1:0] xlat_wait,
    output logic [TMR_W-1:0] load_val
);
    req_kind_e kind_e;

    always_comb begin
        kind_e   = req_kind_e'(kind);
        load_val = (kind_e == KIND_XLAT) ? xlat_wait : plane_wait;
    end
endmodule

// File: rtl/buddy_pair_unit.sv
module buddy_pair_unit #(
    parameter int ADDR_W  = 37,
    parameter int CMP_LSB = 9,
    parameter int TMR_W   = 6,
    localparam int MASK_W = ADDR_W - CMP_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic [TMR_W-1:0]  cfg_plane_wait,
    input  logic [TMR_W-1:0]  cfg_xlat_wait,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_kind,
    output logic              out0_valid,
    output logic [ADDR_W-1:0] out0_addr,
    output logic              out0_kind,
    output logic              out1_valid,
    output logic [ADDR_W-1:0] out1_addr,
    output logic              out1_kind,
    output logic              out_paired
);
    typedef struct packed {
        logic              hold_v;
        logic [ADDR_W-1:0] hold_addr;
        logic              hold_kind;
        logic [TMR_W-1:0]  hold_tmr;
        logic              o0_v;
        logic [ADDR_W-1:0] o0_addr;
        logic              o0_kind;
        logic              o1_v;
        logic [ADDR_W-1:0] o1_addr;
        logic              o1_kind;
        logic              pair;
    } state_t;

    state_t            s_d, s_q;
    logic              buddy_hit;
    logic [TMR_W-1:0]  load_val;

    buddy_match #(.ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB)) u_match (
        .addr_a (s_q.hold_addr),
        .addr_b (in_addr),
        .mask   (cfg_mask),
        .hit    (buddy_hit)
    );

    buddy_wait_sel #(.TMR_W(TMR_W)) u_wait (
        .kind       (in_kind),
        .plane_wait (cfg_plane_wait),
        .xlat_wait  (cfg_xlat_wait),
        .load_val   (load_val)
    );

    always_comb begin
        s_d      = s_q;
        s_d.o0_v = 1'b0;
        s_d.o1_v = 1'b0;
        s_d.pair = 1'b0;

        if (cfg_bypass) begin
            // Flush the slot and pass the arrival straight through.
            if (s_q.hold_v) begin
                s_d.o0_v    = 1'b1;
                s_d.o0_addr = s_q.hold_addr;
                s_d.o0_kind = s_q.hold_kind;
            end
            if (in_valid) begin
                s_d.o1_v    = 1'b1;
                s_d.o1_addr = in_addr;
                s_d.o1_kind = in_kind;
            end
            s_d.hold_v = 1'b0;
        end else if (s_q.hold_v) begin
            if (in_valid && buddy_hit) begin
                // Pair beats expiry on the same edge.
                s_d.o0_v    = 1'b1;
                s_d.o0_addr = s_q.hold_addr;
                s_d.o0_kind = s_q.hold_kind;
                s_d.o1_v    = 1'b1;
                s_d.o1_addr = in_addr;
                s_d.o1_kind = in_kind;
                s_d.pair    = 1'b1;
                s_d.hold_v  = 1'b0;
            end else if (s_q.hold_tmr == '0) begin
                s_d.o0_v    = 1'b1;
                s_d.o0_addr = s_q.hold_addr;
                s_d.o0_kind = s_q.hold_kind;
                s_d.hold_v  = in_valid;
                if (in_valid) begin
                    s_d.hold_addr = in_addr;
                    s_d.hold_kind = in_kind;
                    s_d.hold_tmr  = load_val;
                end
            end else begin
                s_d.hold_tmr = s_q.hold_tmr - 1'b1;
                if (in_valid) begin
                    s_d.o1_v    = 1'b1;
                    s_d.o1_addr = in_addr;
                    s_d.o1_kind = in_kind;
                end
            end
        end else if (in_valid) begin
            s_d.hold_v    = 1'b1;
            s_d.hold_addr = in_addr;
            s_d.hold_kind = in_kind;
            s_d.hold_tmr  = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out0_valid = s_q.o0_v;
    assign out0_addr  = s_q.o0_addr;
    assign out0_kind  = s_q.o0_kind;
    assign out1_valid = s_q.o1_v;
    assign out1_addr  = s_q.o1_addr;
    assign out1_kind  = s_q.o1_kind;
    assign out_paired = s_q.pair;
endmodule

// File: rtl/buddy_pair_checker.sv
module buddy_pair_checker #(
    parameter int ADDR_W  = 37,
    parameter int CMP_LSB = 9,
    localparam int MASK_W = ADDR_W - CMP_LSB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_bypass,
    input logic [MASK_W-1:0] cfg_mask,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out0_valid,
    input logic [ADDR_W-1:0] out0_addr,
    input logic              out1_valid,
    input logic [ADDR_W-1:0] out1_addr,
    input logic              out_paired
);
    logic [MASK_W-1:0] pair_diff;
    assign pair_diff = out0_addr[ADDR_W-1:CMP_LSB] ^ out1_addr[ADDR_W-1:CMP_LSB];

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out0_valid && !out1_valid && !out_paired));

    assert_pair_both_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_paired |-> (out0_valid && out1_valid));

    assert_pair_masked_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_paired |-> ((pair_diff & ~$past(cfg_mask)) == '0));

    assert_lane1_from_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out1_valid |-> ($past(in_valid) && (out1_addr == $past(in_addr))));

    assert_bypass_no_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_bypass) |-> !out_paired);

    assert_bypass_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_bypass) && $past(in_valid)) |-> out1_valid);
endmodule

bind buddy_pair_unit buddy_pair_checker #(.ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB)) u_chk (.*);

// File: tb/buddy_pair_unit_bench.sv
module buddy_pair_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bypass = 1'b0;
    logic [27:0] cfg_mask = '0;
    logic [5:0]  cfg_plane_wait = 6'd4;
    logic [5:0]  cfg_xlat_wait = 6'd4;
    logic        in_valid = 1'b0;
    logic [36:0] in_addr = '0;
    logic        in_kind = 1'b0;
    logic        out0_valid, out0_kind, out1_valid, out1_kind, out_paired;
    logic [36:0] out0_addr, out1_addr;

    always #2.5 clk = ~clk;

    buddy_pair_unit u_buddy_pair_unit (.*);

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // Behavioural reference: a queue of at most one waiting request.
    typedef struct {
        logic [36:0] a;
        logic        k;
        int          t;
    } held_t;
    held_t hq[$];
    bit          e0v, e1v, ep;
    logic [36:0] e0a, e1a;
    logic        e0k, e1k;

    function automatic bit is_buddy(logic [36:0] x, logic [36:0] y, logic [27:0] m);
        for (int i = 0; i < 28; i++)
            if (!m[i] && (x[i+9] != y[i+9])) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        held_t n;
        if (!rst_n) begin
            hq.delete();
            e0v = 0; e1v = 0; ep = 0;
        end else begin
            e0v = 0; e1v = 0; ep = 0;
            n.a = in_addr;
            n.k = in_kind;
            n.t = in_kind ? int'(cfg_xlat_wait) : int'(cfg_plane_wait);
            if (cfg_bypass) begin
                if (hq.size() > 0) begin
                    e0v = 1; e0a = hq[0].a; e0k = hq[0].k; void'(hq.pop_front());
                end
                if (in_valid) begin e1v = 1; e1a = in_addr; e1k = in_kind; end
            end else if (hq.size() > 0) begin
                if (in_valid && is_buddy(hq[0].a, in_addr, cfg_mask)) begin
                    e0v = 1; e0a = hq[0].a; e0k = hq[0].k;
                    e1v = 1; e1a = in_addr; e1k = in_kind; ep = 1;
                    void'(hq.pop_front());
                end else if (hq[0].t == 0) begin
                    e0v = 1; e0a = hq[0].a; e0k = hq[0].k;
                    void'(hq.pop_front());
                    if (in_valid) hq.push_back(n);
                end else begin
                    hq[0].t = hq[0].t - 1;
                    if (in_valid) begin e1v = 1; e1a = in_addr; e1k = in_kind; end
                end
            end else if (in_valid) begin
                hq.push_back(n);
            end
        end
    end

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            bit bad;
            bad = (out0_valid !== e0v) || (out1_valid !== e1v) || (out_paired !== ep) ||
                  (e0v && ((out0_addr !== e0a) || (out0_kind !== e0k))) ||
                  (e1v && ((out1_addr !== e1a) || (out1_kind !== e1k)));
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s cycle compare: got v0=%0b a0=%h v1=%0b a1=%h p=%0b, expected v0=%0b a0=%h v1=%0b a1=%h p=%0b",
                         cur_req, out0_valid, out0_addr, out1_valid, out1_addr, out_paired,
                         e0v, e0a, e1v, e1a, ep);
            end
        end
    end

    task automatic check(string req, string what, logic [36:0] act, logic [36:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [36:0] a, logic k);
        in_valid = 1'b1; in_addr = a; in_kind = k;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        logic [36:0] a, b;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", "out0_valid in reset", {36'd0, out0_valid}, 37'd0);
        check("R1", "out1_valid in reset", {36'd0, out1_valid}, 37'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_paired after reset", {36'd0, out_paired}, 37'd0);

        // R2: low bits differ, page bits equal -> pair
        cur_req = "R2"; cfg_plane_wait = 6'd10;
        a = 37'h0A_BCDE_F123;
        issue(a, 1'b0);
        idle(2);
        issue(a ^ 37'h1FF, 1'b0);
        check("R2", "paired", {36'd0, out_paired}, 37'd1);
        check("R2", "lane0 addr", out0_addr, a);
        check("R2", "lane1 addr", out1_addr, a ^ 37'h1FF);

        // R3: masked bit 3 (address bit 12) ignored
        cur_req = "R3"; cfg_plane_wait = 6'd4; cfg_mask = 28'h8;
        a = 37'h12_3456_7000;
        issue(a, 1'b0);
        issue(a ^ (37'd1 << 12), 1'b0);
        check("R3", "masked bit ignored, paired", {36'd0, out_paired}, 37'd1);
        // R6: unmasked bit (address bit 20) differs -> lane1 single
        cur_req = "R6";
        b = 37'h03_0000_0200;
        issue(b, 1'b0);
        issue(b ^ (37'd1 << 20), 1'b0);
        check("R6", "no pair", {36'd0, out_paired}, 37'd0);
        check("R6", "lane1 single", {36'd0, out1_valid}, 37'd1);
        check("R6", "lane0 idle", {36'd0, out0_valid}, 37'd0);
        idle(8);
        cfg_mask = '0;

        // R4: plane wait 3 -> release after 4th edge
        cur_req = "R4"; cfg_plane_wait = 6'd3;
        a = 37'h01_1111_1000;
        issue(a, 1'b0);
        idle(3);
        check("R4", "not yet released", {36'd0, out0_valid}, 37'd0);
        idle(1);
        check("R4", "released at T+1", {36'd0, out0_valid}, 37'd1);
        check("R4", "released addr", out0_addr, a);
        check("R4", "released alone", {36'd0, out_paired}, 37'd0);
        // R4 with T = 0
        cfg_plane_wait = 6'd0;
        issue(37'h02_2222_2000, 1'b0);
        idle(1);
        check("R4", "T=0 releases after one edge", {36'd0, out0_valid}, 37'd1);
        idle(2);

        // R5: translation uses its own wait value
        cur_req = "R5"; cfg_plane_wait = 6'd2; cfg_xlat_wait = 6'd6;
        a = 37'h04_4444_4000;
        issue(a, 1'b1);
        idle(6);
        check("R5", "xlat not yet released", {36'd0, out0_valid}, 37'd0);
        idle(1);
        check("R5", "xlat released at T+1", {36'd0, out0_valid}, 37'd1);
        check("R5", "xlat kind", {36'd0, out0_kind}, 37'd1);
        idle(2);

        // R7: expiry with non-matching arrival hands over the slot
        cur_req = "R7";
        a = 37'h05_0000_1000; b = 37'h06_0000_2000;
        issue(a, 1'b0);
        idle(2);
        issue(b, 1'b0);
        check("R7", "held released", out0_addr, a);
        check("R7", "held released valid", {36'd0, out0_valid}, 37'd1);
        check("R7", "arrival not passed", {36'd0, out1_valid}, 37'd0);
        idle(3);
        check("R7", "new one released later", out0_addr, b);
        idle(2);

        // R8: match on the expiry edge -> pair
        cur_req = "R8";
        a = 37'h07_0000_3000;
        issue(a, 1'b0);
        idle(2);
        issue(a | 37'h5, 1'b0);
        check("R8", "pair wins over expiry", {36'd0, out_paired}, 37'd1);
        idle(2);

        // R9: bypass flushes and passes through
        cur_req = "R9"; cfg_plane_wait = 6'd20;
        a = 37'h08_0000_4000; b = 37'h08_0000_4040;
        issue(a, 1'b0);
        cfg_bypass = 1'b1;
        issue(b, 1'b0);
        check("R9", "flush lane0", out0_addr, a);
        check("R9", "pass lane1", out1_addr, b);
        check("R9", "no pair", {36'd0, out_paired}, 37'd0);
        issue(b, 1'b1);
        check("R9", "pass-through again", {36'd0, out1_valid}, 37'd1);
        check("R9", "nothing held", {36'd0, out0_valid}, 37'd0);
        cfg_bypass = 1'b0;
        idle(2);

        // Mixed traffic checked by the reference model only
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            cfg_mask       = (i % 50 < 25) ? 28'h0 : 28'h3;
            cfg_plane_wait = 6'($urandom_range(0, 5));
            cfg_xlat_wait  = 6'($urandom_range(0, 5));
            cfg_bypass     = ($urandom_range(0, 19) == 0);
            in_valid       = ($urandom_range(0, 2) != 0);
            in_addr        = {35'($urandom_range(0, 3)), 2'b00} << 9 | 37'($urandom_range(0, 511));
            in_kind        = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        in_valid = 1'b0; cfg_bypass = 1'b0;
        idle(10);
        finish_run();
    end
endmodule